// File: doc/BRIEF.md
# Synchronous Controller for a 1-bit Asynchronous Static RAM

This block lets logic on the system clock use an external asynchronous static RAM that holds one bit per word. On its user side it takes one request at a time through a valid/ready handshake. A request carries an address, a write flag and a write bit. A completed read returns its bit with a one-cycle valid strobe. On its memory side it drives registered address, data-in, active-low chip-select and active-low write-strobe pins, and it samples the memory's separate data-out pin.

All memory timing is counted in clock cycles. A write first presents the address and data with the chip selected and the write strobe high for one cycle. It then pulls the write strobe low for `WE_CYC` cycles and raises it. Address and data stay put for one more cycle, so the rising strobe, which ends the write, sees both setup and hold. A read holds the address for `RD_CYC` cycles and then registers the data-out pin. When no request follows a finished access, the chip select goes high, which puts the memory into its low-power deselected state. A request that follows at once keeps the chip selected.

Top module: `sram1b_ctrl`

## Requirements
- R1: While reset is high and after its release, mem_ce_n and mem_we_n are 1, rsp_valid is 0 and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 until the access ends. That is RD_CYC cycles after the accepting edge for a read, and WE_CYC+2 cycles after it for a write.
- R3: For a write accepted at edge n, the address and data-in are driven from edge n with mem_ce_n at 0 and mem_we_n at 1. mem_we_n falls at edge n+1, so the address is stable for one full cycle before the write strobe goes low.
- R4: mem_we_n is 0 for exactly WE_CYC consecutive cycles per write, and it is 0 only while mem_ce_n is 0.
- R5: mem_addr and mem_din do not change while mem_we_n is 0. They also stay unchanged for the cycle after mem_we_n rises (hold after the write ends).
- R6: For a read accepted at edge n, mem_ce_n is 0 and mem_we_n is 1, and mem_addr holds the request address from edge n on. The data-out pin is registered at edge n+RD_CYC. rsp_valid is 1 with that bit on rsp_rdata for exactly the one cycle after that edge.
- R7: rsp_valid is 1 only in the cycle that ends a read, never after a write.
- R8: If the controller is idle (req_ready 1) and req_valid is 0 at an edge, mem_ce_n is 1 after that edge. A request taken straight after an access keeps mem_ce_n at 0 with no gap.
- R9: A read returns the bit most recently written to the same address. An address that was never written reads as 0 in the memory model.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Word address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle strobe: read bit available |
| rsp_rdata | output | 1 | Bit returned by a read |
| mem_addr | output | ADDR_W | Address pins of the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_din | output | 1 | Data-in pin of the memory |
| mem_dout | input | 1 | Data-out pin of the memory |

## Verification
The memory model in the bench returns the inverted bit until the address has been held for RD_CYC cycles, so a capture even one cycle early is caught. It commits a write only when the strobe rises, using the address and data seen during the strobe. Stimulus covers isolated writes and reads with idle gaps between them, which shows the chip select dropping. It also covers back-to-back chains, which show the select held low, and alternating 0/1 patterns at the lowest, highest and checkerboard addresses, which catch swapped or stuck address and data bits. Overwrites followed by read-back of the same address separate a missing write from a late one. A pseudo-random mix of mixed reads and writes with varying gaps is compared with the reference model on every cycle for handshake, select, strobe and read data.

// File: rtl/sram1b_pkg.sv
`timescale 1ns/1ps
package sram1b_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_READ  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/sram1b_timer.sv
`timescale 1ns/1ps
module sram1b_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (dec && (count != '0)) begin
      count <= count - 1'b1;
    end
  end

  assign zero = (count == '0);
endmodule

// File: rtl/sram1b_pins.sv
`timescale 1ns/1ps
module sram1b_pins #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              din_in,
  input  logic              ce_on,
  input  logic              ce_off,
  input  logic              we_on,
  input  logic              we_off,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_din,
  output logic              mem_ce_n,
  output logic              mem_we_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_din  <= 1'b0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
    end else begin
      if (latch) begin
        mem_addr <= addr_in;
        mem_din  <= din_in;
      end
      if (ce_on) begin
        mem_ce_n <= 1'b0;
      end else if (ce_off) begin
        mem_ce_n <= 1'b1;
      end
      if (we_on) begin
        mem_we_n <= 1'b0;
      end else if (we_off) begin
        mem_we_n <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sram1b_rdcap.sv
`timescale 1ns/1ps
module sram1b_rdcap (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic dout_pin,
  output logic rd_valid,
  output logic rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 1'b0;
    end else begin
      rd_valid <= capture;
      if (capture) begin
        rd_data <= dout_pin;
      end
    end
  end
endmodule

// File: rtl/sram1b_ctrl.sv
`timescale 1ns/1ps
module sram1b_ctrl
  import sram1b_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int WE_CYC = 2,
  parameter int RD_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_din,
  input  logic              mem_dout
);
  localparam int MAX_CYC = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WE_LOAD = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);

  seq_state_t       state;
  logic             accept;
  logic             t_zero;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_dec;
  logic             capture;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (accept) state <= req_write ? ST_SETUP : ST_READ;
        ST_SETUP: state <= ST_PULSE;
        ST_PULSE: if (t_zero) state <= ST_HOLD;
        ST_HOLD:  state <= ST_IDLE;
        ST_READ:  if (t_zero) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (accept && !req_write) begin
      t_load = 1'b1;
      t_val  = RD_LOAD;
    end else if (state == ST_SETUP) begin
      t_load = 1'b1;
      t_val  = WE_LOAD;
    end
  end

  assign t_dec   = (state == ST_PULSE) || (state == ST_READ);
  assign capture = (state == ST_READ) && t_zero;

  sram1b_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .dec      (t_dec),
    .zero     (t_zero)
  );

  sram1b_pins #(.ADDR_W(ADDR_W)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .latch    (accept),
    .addr_in  (req_addr),
    .din_in   (req_wdata),
    .ce_on    (accept),
    .ce_off   (req_ready && !req_valid),
    .we_on    (state == ST_SETUP),
    .we_off   ((state == ST_PULSE) && t_zero),
    .mem_addr (mem_addr),
    .mem_din  (mem_din),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n)
  );

  sram1b_rdcap u_rdcap (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture),
    .dout_pin (mem_dout),
    .rd_valid (rsp_valid),
    .rd_data  (rsp_rdata)
  );
endmodule

// File: rtl/sram1b_ctrl_chk.sv
`timescale 1ns/1ps
module sram1b_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int WE_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_din
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (!mem_we_n) begin
      low_cnt <= low_cnt + 1;
    end else begin
      low_cnt <= '0;
    end
  end

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_we_setup_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_din) && !$past(mem_ce_n)));

  assert_we_inside_ce_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  assert_we_width_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (low_cnt == WE_CYC));

  assert_pins_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_din)));

  assert_write_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_din)));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_no_valid_in_write_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !rsp_valid);

  assert_idle_deselect_R8: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !req_valid) |=> mem_ce_n);
endmodule

bind sram1b_ctrl sram1b_ctrl_chk #(.ADDR_W(ADDR_W), .WE_CYC(WE_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_din   (mem_din)
);

// File: tb/sram1b_ctrl_test.sv
`timescale 1ns/1ps
module sram1b_ctrl_test;
  localparam int AW  = 18;
  localparam int WEC = 2;
  localparam int RDC = 3;
  localparam logic [AW-1:0] AMAX = {AW{1'b1}};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic          req_wdata = 1'b0;
  logic          rsp_valid;
  logic          rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n;
  logic          mem_we_n;
  logic          mem_din;
  logic          mem_dout = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sram1b_ctrl #(.ADDR_W(AW), .WE_CYC(WEC), .RD_CYC(RDC)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_din(mem_din), .mem_dout(mem_dout)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (rst) cyc = 0;
    else     cyc = cyc + 1;
  end

  // Memory pin model and reference model, all evaluated at the falling edge.
  bit          pmem [int];
  bit          emem [int];
  int          q_cyc [$];
  bit          q_dat [$];
  int          age = 0;
  int          free_cyc = 0;
  int          we_lo_first = -1;
  int          we_lo_last  = -1;
  int          low_run = 0;
  bit          pend = 1'b0;
  bit          pend_wr = 1'b0;
  int          pend_a = 0;
  bit          pend_d = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic          p_din = 1'b0;
  logic          p_we = 1'b1;
  logic          p_rd = 1'b0;

  always @(negedge clk) begin
    int c;
    bit rd_now;
    bit v;
    c = cyc;
    if (rst) begin
      age = 0; pend = 1'b0; free_cyc = 0; p_we = 1'b1; p_rd = 1'b0; low_run = 0;
      mem_dout = 1'b0;
    end else begin
      // Reference model: apply the request accepted at edge c.
      if (pend) begin
        if (pend_wr) begin
          emem[pend_a] = pend_d;
          free_cyc = c + WEC + 2;
          we_lo_first = c + 1;
          we_lo_last  = c + WEC;
        end else begin
          q_cyc.push_back(c + RDC);
          q_dat.push_back(emem.exists(pend_a) ? emem[pend_a] : 1'b0);
          free_cyc = c + RDC;
        end
        pend = 1'b0;
      end
      // R2: handshake
      check(req_ready == (c >= free_cyc), "R2 req_ready", req_ready, c >= free_cyc);
      // R6/R7: read strobe and data
      if (q_cyc.size() > 0 && q_cyc[0] == c) begin
        check(rsp_valid == 1'b1, "R6 rsp_valid", rsp_valid, 1);
        check(rsp_rdata == q_dat[0], "R9 rsp_rdata", rsp_rdata, q_dat[0]);
        void'(q_cyc.pop_front());
        void'(q_dat.pop_front());
      end else begin
        check(rsp_valid == 1'b0, "R7 rsp_valid", rsp_valid, 0);
      end
      // R8: chip select
      if (c < free_cyc)      check(mem_ce_n == 1'b0, "R8 ce_n busy", mem_ce_n, 0);
      else if (c > free_cyc) check(mem_ce_n == 1'b1, "R8 ce_n idle", mem_ce_n, 1);
      // R3/R4: write strobe window
      begin
        bit exp_we;
        exp_we = !(c >= we_lo_first && c <= we_lo_last);
        check(mem_we_n == exp_we, "R4 we_n window", mem_we_n, exp_we);
      end
      if (!mem_we_n) check(mem_ce_n == 1'b0, "R4 we_n inside ce_n", mem_ce_n, 0);
      if (p_we && !mem_we_n)
        check(mem_addr == p_addr && mem_din == p_din, "R3 setup", mem_addr, p_addr);
      if (!p_we)
        check(mem_addr == p_addr && mem_din == p_din, "R5 addr/din steady", mem_addr, p_addr);
      if (!mem_we_n) low_run++;
      else begin
        if (!p_we) check(low_run == WEC, "R4 pulse width", low_run, WEC);
        low_run = 0;
      end
      // Pin model: write commits when the strobe or select rises.
      if (!p_we && (mem_we_n || mem_ce_n)) pmem[int'(p_addr)] = p_din;
      rd_now = !mem_ce_n && mem_we_n;
      if (rd_now && p_rd && mem_addr == p_addr) age++;
      else if (rd_now) age = 1;
      else age = 0;
      v = pmem.exists(int'(mem_addr)) ? pmem[int'(mem_addr)] : 1'b0;
      mem_dout = rd_now ? ((age >= RDC) ? v : ~v) : 1'b0;
      p_addr = mem_addr; p_din = mem_din; p_we = mem_we_n; p_rd = rd_now;
      // Handshake that completes at the next rising edge.
      if (req_valid && req_ready) begin
        pend = 1'b1; pend_wr = req_write; pend_a = int'(req_addr); pend_d = req_wdata;
      end
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input bit d);
    bit r;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk); r = req_ready;
      @(posedge clk); #1;
      if (r) break;
    end
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    int seed;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(mem_ce_n == 1'b1, "R1 ce_n", mem_ce_n, 1);
    check(mem_we_n == 1'b1, "R1 we_n", mem_we_n, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    check(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_ce_n == 1'b1 && mem_we_n == 1'b1, "R1 after release", mem_ce_n, 1);
    @(posedge clk); #1;
    // Isolated write and read (R3, R6, R8 deselect between)
    issue(1'b1, 18'h00000, 1'b1); idle(3);
    issue(1'b0, 18'h00000, 1'b0); idle(3);
    // Back-to-back writes at corner addresses (R8 select held)
    issue(1'b1, AMAX, 1'b1);
    issue(1'b1, 18'h15555, 1'b1);
    issue(1'b1, 18'h2AAAA, 1'b0);
    issue(1'b0, AMAX, 1'b0);
    issue(1'b0, 18'h15555, 1'b0);
    issue(1'b0, 18'h2AAAA, 1'b0);
    issue(1'b0, 18'h00001, 1'b0); // never written: R9 reads 0
    idle(2);
    // Overwrite then read back (R9)
    issue(1'b1, 18'h00000, 1'b0);
    issue(1'b0, 18'h00000, 1'b0);
    issue(1'b1, AMAX, 1'b0);
    issue(1'b0, AMAX, 1'b0);
    idle(4);
    // Mixed pseudo-random traffic
    seed = 7;
    for (int i = 0; i < 300; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      issue(seed[20], {seed[10:8], 15'h0} | AW'(seed[6:4]), seed[13]);
      if (seed[17:16] == 2'b00) idle(int'(seed[19:18]) + 1);
    end
    idle(RDC + WEC + 6);
    if (q_cyc.size() != 0) check(1'b0, "R6 pending reads", q_cyc.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule